// File: doc/BRIEF.md
# Navigation Sentence Fix Detector

This block watches the character stream coming out of a serial receiver attached to a satellite navigation module. It picks out the recommended-minimum position sentences and turns their one-letter status field into a fix flag. Downstream oscillator discipline logic uses that flag to decide whether the once-per-second timing pulse can be trusted. From the same sentence the block also keeps the six UTC time characters (hhmmss) and the six date characters (ddmmyy) so that status logic can show them.

Bytes come in on a valid/ready stream. The block never applies back-pressure: `in_ready` stays high, and a byte is consumed on every clock edge where `in_valid` is high. The producer may therefore present one byte per cycle with no wait states. A byte offered with `in_valid` low is never consumed.

Fields are split by commas. The header counts as field 0, the time is field 1, the status is field 2 and the date is field 9. The outputs change only when a sentence reaches its terminator, so a partial sentence never disturbs them. An external one-second tick drives a staleness timeout that withdraws the fix when no complete sentence of the right kind has arrived for a while.

Top module: `rmc_fix_detect`

## Requirements
- R1: `in_ready` is 1 at all times, and a byte is consumed on every cycle in which `in_valid` is 1.
- R2: A sentence counts only when it starts with the seven characters `$GPRMC,`. Any other header, including one that differs in a single letter, causes no update pulse and no output change.
- R3: A `$` (0x24) received at any point restarts header matching and throws away the sentence in progress.
- R4: A sentence is committed when a terminator, `*` (0x2A) or CR (0x0D), arrives after at least nine commas. `upd_pulse` is 1 for exactly the one cycle that follows the clock edge that consumed the terminator.
- R5: On commit, `fix_valid` becomes 1 if the first character of field 2 is `A` (0x41). It becomes 0 if that character is `V`, any other value, or if field 2 is empty.
- R6: On commit, the first six characters of field 1 are copied to `utc_time`, and the first six characters of field 9 are copied to `utc_date`. The first character goes to bits [47:40] and the sixth to bits [7:0].
- R7: A terminator that arrives before the ninth comma leaves every output unchanged and gives no pulse.
- R8: When TIMEOUT_S pulses of `tick_1hz` have occurred since the last commit, `fix_valid` is 0 from the edge that consumed the last of them. A commit restarts the count.
- R9: After reset, `fix_valid` and `upd_pulse` are 0 and every character of `utc_time` and `utc_date` is `0` (0x30). A field shorter than six characters is padded with 0x30 in its remaining positions.
- R10: Bytes presented with `in_valid` low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is offered on `in_data` |
| in_data | input | 8 | ASCII character from the serial receiver |
| in_ready | output | 1 | Always 1; the block accepts a byte every cycle |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| fix_valid | output | 1 | Most recent committed status was `A` and not stale |
| upd_pulse | output | 1 | One-cycle pulse after each committed sentence |
| utc_time | output | 48 | Six ASCII characters hhmmss |
| utc_date | output | 48 | Six ASCII characters ddmmyy |

## Verification
The assertions check several properties on every cycle. The stream body can only be entered on a comma. The field counter only moves backwards when a new sentence starts. The update pulse never lasts longer than one cycle. The latched time and date never change unless an update pulse accompanies the change. The fix can only rise straight after a commit that carried `A`, and it is never held once the timeout count is full. Other behaviour can only be shown by the bench scenarios: rejection of near-miss headers, discarding a sentence cut short by `$`, refusal of short sentences, padding of short fields, CR as a terminator, bytes offered while invalid, and the exact tick on which a stale fix drops.

// File: rtl/rmc_fix_pkg.sv
package rmc_fix_pkg;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_HDR,
    PS_BODY
  } prs_state_t;

  localparam logic [7:0] CH_START  = 8'h24;
  localparam logic [7:0] CH_COMMA  = 8'h2C;
  localparam logic [7:0] CH_STAR   = 8'h2A;
  localparam logic [7:0] CH_CR     = 8'h0D;
  localparam logic [7:0] CH_FIX_OK = 8'h41;
  localparam logic [7:0] CH_ZERO   = 8'h30;

  localparam int HDR_LEN = 5;
  localparam logic [8*HDR_LEN-1:0] HDR_TAG = "GPRMC";

  function automatic logic [7:0] hdr_char(input int idx);
    return HDR_TAG[8*(HDR_LEN-1-idx) +: 8];
  endfunction

endpackage

// File: rtl/rmc_hdr_match.sv
module rmc_hdr_match
  import rmc_fix_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_en,
  input  logic [7:0] byte_in,
  output logic       sent_start,
  output logic       body_byte,
  output logic       term_hit,
  output logic       body_active
);

  localparam int POS_W = $clog2(HDR_LEN + 1);

  prs_state_t       state_q;
  logic [POS_W-1:0] pos_q;
  logic             is_start;
  logic             is_term;

  always_comb begin
    is_start    = byte_en && (byte_in == CH_START);
    is_term     = (byte_in == CH_STAR) || (byte_in == CH_CR);
    sent_start  = is_start;
    term_hit    = byte_en && (state_q == PS_BODY) && is_term;
    body_byte   = byte_en && (state_q == PS_BODY) && !is_start && !is_term;
    body_active = (state_q == PS_BODY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      pos_q   <= '0;
    end else if (is_start) begin
      state_q <= PS_HDR;
      pos_q   <= '0;
    end else if (byte_en) begin
      case (state_q)
        PS_HDR: begin
          if (pos_q == POS_W'(HDR_LEN)) begin
            state_q <= (byte_in == CH_COMMA) ? PS_BODY : PS_IDLE;
          end else if (byte_in == hdr_char(int'(pos_q))) begin
            pos_q <= pos_q + 1'b1;
          end else begin
            state_q <= PS_IDLE;
          end
        end
        PS_BODY: begin
          if (is_term) state_q <= PS_IDLE;
        end
        default: state_q <= PS_IDLE;
      endcase
    end
  end

  AST_BODY_AFTER_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(body_active) |-> $past(byte_en && (byte_in == CH_COMMA))); // R2

endmodule

// File: rtl/rmc_field_track.sv
module rmc_field_track
  import rmc_fix_pkg::*;
#(
  parameter int DIGITS       = 6,
  parameter int FIELD_W      = 4,
  parameter int TIME_FIELD   = 1,
  parameter int STATUS_FIELD = 2,
  parameter int DATE_FIELD   = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sent_start,
  input  logic                  body_byte,
  input  logic [7:0]            byte_in,
  output logic [FIELD_W-1:0]    field_idx,
  output logic [7:0]            status_ch,
  output logic [8*DIGITS-1:0]   time_sh,
  output logic [8*DIGITS-1:0]   date_sh
);

  localparam int CHAR_W = $clog2(DIGITS + 1);
  localparam logic [FIELD_W-1:0] FIELD_MAX = '1;

  logic [FIELD_W-1:0] field_q;
  logic [CHAR_W-1:0]  char_q;
  logic               is_comma;
  logic               data_byte;

  assign is_comma  = (byte_in == CH_COMMA);
  assign data_byte = body_byte && !is_comma;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q   <= '0;
      char_q    <= '0;
      status_ch <= '0;
    end else if (sent_start) begin
      field_q   <= FIELD_W'(1);
      char_q    <= '0;
      status_ch <= '0;
    end else if (body_byte) begin
      if (is_comma) begin
        if (field_q != FIELD_MAX) field_q <= field_q + 1'b1;
        char_q <= '0;
      end else begin
        if (char_q != CHAR_W'(DIGITS)) char_q <= char_q + 1'b1;
        if ((field_q == FIELD_W'(STATUS_FIELD)) && (char_q == '0)) status_ch <= byte_in;
      end
    end
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_slot
    logic [7:0] tslot_q;
    logic [7:0] dslot_q;
    logic       hit;

    assign hit = data_byte && (char_q == CHAR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tslot_q <= CH_ZERO;
        dslot_q <= CH_ZERO;
      end else if (sent_start) begin
        tslot_q <= CH_ZERO;
        dslot_q <= CH_ZERO;
      end else if (hit) begin
        if (field_q == FIELD_W'(TIME_FIELD)) tslot_q <= byte_in;
        if (field_q == FIELD_W'(DATE_FIELD)) dslot_q <= byte_in;
      end
    end

    assign time_sh[8*(DIGITS-1-g) +: 8] = tslot_q;
    assign date_sh[8*(DIGITS-1-g) +: 8] = dslot_q;
  end

  assign field_idx = field_q;

  AST_FIELD_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (field_q < $past(field_q)) |-> $past(sent_start)); // R3

endmodule

// File: rtl/rmc_fix_hold.sv
module rmc_fix_hold #(
  parameter int TIMEOUT_S = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic status_ok,
  input  logic tick,
  output logic fix
);

  localparam int CNT_W = $clog2(TIMEOUT_S + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(TIMEOUT_S);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_S - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fix   <= 1'b0;
    end else if (commit) begin
      cnt_q <= '0;
      fix   <= status_ok;
    end else if (tick && (cnt_q != CNT_FULL)) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) fix <= 1'b0;
    end
  end

  AST_FIX_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fix) |-> $past(commit && status_ok)); // R5

  AST_STALE_NO_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_FULL) |-> !fix); // R8

endmodule

// File: rtl/rmc_fix_detect.sv
module rmc_fix_detect
  import rmc_fix_pkg::*;
#(
  parameter int TIMEOUT_S = 3,
  parameter int DIGITS    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [7:0]          in_data,
  output logic                in_ready,
  input  logic                tick_1hz,
  output logic                fix_valid,
  output logic                upd_pulse,
  output logic [8*DIGITS-1:0] utc_time,
  output logic [8*DIGITS-1:0] utc_date
);

  localparam int FIELD_W      = 4;
  localparam int TIME_FIELD   = 1;
  localparam int STATUS_FIELD = 2;
  localparam int DATE_FIELD   = 9;

  logic                byte_en;
  logic                sent_start;
  logic                body_byte;
  logic                term_hit;
  logic                body_active;
  logic [FIELD_W-1:0]  field_idx;
  logic [7:0]          status_ch;
  logic [8*DIGITS-1:0] time_sh;
  logic [8*DIGITS-1:0] date_sh;
  logic                commit;

  assign in_ready = 1'b1;
  assign byte_en  = in_valid && in_ready;

  rmc_hdr_match u_hdr (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_en     (byte_en),
    .byte_in     (in_data),
    .sent_start  (sent_start),
    .body_byte   (body_byte),
    .term_hit    (term_hit),
    .body_active (body_active)
  );

  rmc_field_track #(
    .DIGITS       (DIGITS),
    .FIELD_W      (FIELD_W),
    .TIME_FIELD   (TIME_FIELD),
    .STATUS_FIELD (STATUS_FIELD),
    .DATE_FIELD   (DATE_FIELD)
  ) u_fields (
    .clk        (clk),
    .rst_n      (rst_n),
    .sent_start (sent_start),
    .body_byte  (body_byte),
    .byte_in    (in_data),
    .field_idx  (field_idx),
    .status_ch  (status_ch),
    .time_sh    (time_sh),
    .date_sh    (date_sh)
  );

  assign commit = term_hit && (field_idx >= FIELD_W'(DATE_FIELD));

  rmc_fix_hold #(
    .TIMEOUT_S (TIMEOUT_S)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .status_ok (status_ch == CH_FIX_OK),
    .tick      (tick_1hz),
    .fix       (fix_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_pulse <= 1'b0;
      utc_time  <= {DIGITS{CH_ZERO}};
      utc_date  <= {DIGITS{CH_ZERO}};
    end else begin
      upd_pulse <= commit;
      if (commit) begin
        utc_time <= time_sh;
        utc_date <= date_sh;
      end
    end
  end

  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |=> !upd_pulse); // R4

  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(utc_time) |-> upd_pulse); // R6

  AST_DATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(utc_date) |-> upd_pulse); // R6

endmodule

// File: tb/rmc_fix_detect_tb.sv
module rmc_fix_detect_tb;

  typedef struct packed {
    logic [639:0] text;
    logic [1:0]   upd;
    logic         fix;
    logic [47:0]  tm;
    logic [47:0]  dt;
    logic [15:0]  tag;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{"$GPRMC,123519,A,4807.038,N,01131.000,E,022.4,084.4,230394,003.1,W*6A",
      2'd1, 1'b1, "123519", "230394", "R6"},
    '{"$GPGGA,999999,A,,,,,,,888888,*00",
      2'd0, 1'b1, "123519", "230394", "R2"},
    '{"$GPRMC,081122,V,,,,,,,151224\015",
      2'd1, 1'b0, "081122", "151224", "R4"},
    '{"$GPRMC,220000,A,1,N,2,E,0,0,$GPRMC,010203,A,,,,,,,040506,*00",
      2'd1, 1'b1, "010203", "040506", "R3"},
    '{"$GPRMC,111111,A,,,*00",
      2'd0, 1'b1, "010203", "040506", "R7"},
    '{"$GPRMC,2359,X,,,,,,,311299,*00",
      2'd1, 1'b0, "235900", "311299", "R5"},
    '{"$GPRMC,020304,A,,,,,,,010100,*00",
      2'd1, 1'b1, "020304", "010100", "R5"},
    '{"$GPRMB,000000,V,,,,,,,000000,*00",
      2'd0, 1'b1, "020304", "010100", "R2"}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        tick_1hz = 1'b0;
  logic        in_ready;
  logic        fix_valid;
  logic        upd_pulse;
  logic [47:0] utc_time;
  logic [47:0] utc_date;

  int checks = 0;
  int fails  = 0;
  int upd_seen = 0;
  bit ready_dropped = 1'b0;

  always #10 clk = ~clk;

  rmc_fix_detect u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .tick_1hz  (tick_1hz),
    .fix_valid (fix_valid),
    .upd_pulse (upd_pulse),
    .utc_time  (utc_time),
    .utc_date  (utc_date)
  );

  always @(negedge clk) begin
    if (upd_pulse) upd_seen++;
    if (rst_n && !in_ready) ready_dropped = 1'b1;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_text(input logic [639:0] t, input logic vld);
    bit started = 1'b0;
    for (int i = 79; i >= 0; i--) begin
      if (started || t[8*i +: 8] != 8'h00) begin
        started = 1'b1;
        @(negedge clk);
        in_data  = t[8*i +: 8];
        in_valid = vld;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 8'h00;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state, R1 ready
    check("R9 fix", 64'(fix_valid), 64'd0);
    check("R9 upd", 64'(upd_pulse), 64'd0);
    check("R9 time", 64'(utc_time), 64'("000000"));
    check("R9 date", 64'(utc_date), 64'("000000"));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", 64'(in_ready), 64'd1);

    for (int v = 0; v < NVEC; v++) begin
      upd_seen = 0;
      send_text(VECS[v].text, 1'b1);
      check($sformatf("%s upd v%0d", VECS[v].tag, v), 64'(upd_seen), 64'(VECS[v].upd));
      check($sformatf("%s fix v%0d", VECS[v].tag, v), 64'(fix_valid), 64'(VECS[v].fix));
      check($sformatf("%s time v%0d", VECS[v].tag, v), 64'(utc_time), 64'(VECS[v].tm));
      check($sformatf("%s date v%0d", VECS[v].tag, v), 64'(utc_date), 64'(VECS[v].dt));
    end

    // R10: same bytes offered with valid low change nothing
    upd_seen = 0;
    send_text("$GPRMC,101010,V,,,,,,,202020,*00", 1'b0);
    check("R10 upd", 64'(upd_seen), 64'd0);
    check("R10 fix", 64'(fix_valid), 64'd1);
    check("R10 time", 64'(utc_time), 64'("020304"));

    // R8: fix drops on the third tick since last commit
    pulse_tick();
    pulse_tick();
    check("R8 fix after 2 ticks", 64'(fix_valid), 64'd1);
    pulse_tick();
    check("R8 fix after 3 ticks", 64'(fix_valid), 64'd0);

    // R8: a commit restarts the count
    send_text("$GPRMC,030303,A,,,,,,,030303,*00", 1'b1);
    check("R5 fix regained", 64'(fix_valid), 64'd1);
    pulse_tick();
    pulse_tick();
    send_text("$GPRMC,040404,A,,,,,,,040404,*00", 1'b1);
    pulse_tick();
    pulse_tick();
    check("R8 fix after restart", 64'(fix_valid), 64'd1);
    pulse_tick();
    check("R8 fix stale again", 64'(fix_valid), 64'd0);
    check("R6 time latest", 64'(utc_time), 64'("040404"));

    check("R1 ready never dropped", 64'(ready_dropped), 64'd0);
    summary();
    $finish;
  end

endmodule